// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns a set of digital supply-comparator flags into the reset and warning outputs of a supply supervisor. One flag says that the main supply has climbed past roughly 1 V and another says that it is above its first trip level. A third flag reports that a second monitored rail is above its own trip level, and a fourth that the backup battery is valid. An active-low push-button input can also request a reset.

The block drives three outputs: an active-low system reset, a bus-inhibit level that blocks serial traffic while reset is held, and an active-low early-warning flag for the second rail. Every delay is counted in ticks of a slow clock-enable input, `tick_i`.

Reset is released only after every reset cause has stayed clear for a parameterised number of ticks. The push-button is synchronised and debounced before it takes part, so a bouncing contact produces one assertion and one release. The second-rail flag follows its comparator without delay. It is forced to its idle level whenever neither the main supply nor the battery can power the monitor. All flags are plain levels: the block has no data stream, so it uses no valid/ready handshake.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `sys_rst_n_o` is 0 and `bus_block_o` is 1. The release count starts full, so reset stays asserted for at least `HOLD_TICKS` ticks after `rst_n` rises.
- R2: `sys_rst_n_o` is 0 in the same cycle that `main_live_i` is 0 or `main_ok_i` is 0, with no register in the path.
- R3: The release count reloads to `HOLD_TICKS` on every clock edge at which a cause is present. The causes are `main_live_i` low, `main_ok_i` low, or the debounced button pressed. Once all causes are clear, the count drops by one on each edge with `tick_i` high. `sys_rst_n_o` rises in the cycle after the count reaches 0, which is exactly `HOLD_TICKS` ticked edges after the causes clear.
- R4: `bus_block_o` is 1 exactly when `sys_rst_n_o` is 0.
- R5: `mr_n_i` passes through `SYNC_STAGES` flip-flops, which reset to 1. The debounced level changes only after `DEB_TICKS` consecutive ticked samples that all differ from it. A run of differing samples shorter than that has no effect on any output.
- R6: A debounced press (level 0) asserts `sys_rst_n_o` from the edge at which it is accepted. Reset is released `HOLD_TICKS` ticks after the debounced level returns to 1.
- R7: When `main_ok_i` or `batt_ok_i` is 1, `rail2_fail_n_o` equals `rail2_ok_i` in the same cycle, with no delay in either direction.
- R8: When `main_ok_i` and `batt_ok_i` are both 0, `rail2_fail_n_o` holds 1 whatever `rail2_ok_i` does.
- R9: On edges with `tick_i` low, neither the debounced button level nor a counting-down release count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | Slow time-base enable, one clock wide |
| main_live_i | input | 1 | Main supply above about 1 V |
| main_ok_i | input | 1 | Main supply above trip 1 |
| rail2_ok_i | input | 1 | Second rail above trip 2 |
| batt_ok_i | input | 1 | Backup battery valid |
| mr_n_i | input | 1 | Asynchronous active-low push-button |
| sys_rst_n_o | output | 1 | Active-low system reset |
| bus_block_o | output | 1 | High while serial traffic is blocked |
| rail2_fail_n_o | output | 1 | Active-low second-rail early warning |

## Verification
The bench builds the block with `HOLD_TICKS` = 6 and `DEB_TICKS` = 3. With these values a full release wait and a full debounce both fit within a few dozen cycles. Random supply drops, button bursts and tick gaps then regularly land in the middle of a countdown, which exercises the reload-and-restart path many times. The short debounce length also lets a directed glitch of exactly `DEB_TICKS`-1 samples sit at the boundary between an ignored pulse and an accepted press. `SYNC_STAGES` keeps its default of 2, so the bench model uses a two-stage button pipeline.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef struct packed {
    logic live;
    logic main_ok;
    logic rail2_ok;
    logic batt_ok;
  } supply_flags_t;

  function automatic logic any_cause(supply_flags_t f, logic btn_pressed);
    return !f.live || !f.main_ok || btn_pressed;
  endfunction
endpackage

// File: rtl/sup_mr_filter.sv
module sup_mr_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_TICKS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pin_n_i,
  output logic level_o
);
  localparam int DW = (DEB_TICKS < 2) ? 1 : $clog2(DEB_TICKS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DW-1:0]          run_q;
  logic                   level_q;
  logic                   sample;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[s] <= 1'b1;
        else        sync_q[s] <= pin_n_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[s] <= 1'b1;
        else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign sample = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      run_q   <= '0;
    end else if (tick_i) begin
      if (sample == level_q) begin
        run_q <= '0;
      end else if (run_q == DW'(DEB_TICKS - 1)) begin
        level_q <= sample;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;

  AST_LEVEL_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(level_q)); // R9
  AST_LEVEL_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> $past(tick_i)); // R5
endmodule

// File: rtl/sup_release_timer.sv
module sup_release_timer #(
  parameter int HOLD_TICKS = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic cause_i,
  output logic busy_o
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= FULL;
    else if (cause_i)                 cnt_q <= FULL;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_COUNT_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cause_i) |=> $stable(cnt_q)); // R9
  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(tick_i) && !$past(cause_i)); // R3
  AST_CAUSE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cause_i |=> busy_o); // R3
endmodule

// File: rtl/sup_rail2_gate.sv
module sup_rail2_gate (
  input  logic main_ok_i,
  input  logic batt_ok_i,
  input  logic rail2_ok_i,
  output logic fail_n_o
);
  logic powered;
  assign powered  = main_ok_i | batt_ok_i;
  assign fail_n_o = powered ? rail2_ok_i : 1'b1;

  always_comb begin
    if (!main_ok_i && !batt_ok_i)
      AST_UNPOWERED_IDLE: assert (fail_n_o == 1'b1); // R8
  end
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import sup_pkg::*;
#(
  parameter int HOLD_TICKS  = 150,
  parameter int DEB_TICKS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic main_live_i,
  input  logic main_ok_i,
  input  logic rail2_ok_i,
  input  logic batt_ok_i,
  input  logic mr_n_i,
  output logic sys_rst_n_o,
  output logic bus_block_o,
  output logic rail2_fail_n_o
);
  supply_flags_t flags;
  logic          btn_level;
  logic          cause;
  logic          hold_busy;

  assign flags = '{live: main_live_i, main_ok: main_ok_i,
                   rail2_ok: rail2_ok_i, batt_ok: batt_ok_i};

  sup_mr_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_TICKS(DEB_TICKS)) u_mr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .pin_n_i (mr_n_i),
    .level_o (btn_level)
  );

  assign cause = any_cause(flags, !btn_level);

  sup_release_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .cause_i (cause),
    .busy_o  (hold_busy)
  );

  assign sys_rst_n_o = !(cause || hold_busy);
  assign bus_block_o = !sys_rst_n_o;

  sup_rail2_gate u_rail2 (
    .main_ok_i  (flags.main_ok),
    .batt_ok_i  (flags.batt_ok),
    .rail2_ok_i (flags.rail2_ok),
    .fail_n_o   (rail2_fail_n_o)
  );

  AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n_o) |-> $past(main_ok_i) && $past(main_live_i)); // R3
  AST_PRESS_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !btn_level |-> !sys_rst_n_o); // R6
  AST_LOW_SUPPLY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !main_ok_i |=> !sys_rst_n_o); // R2
endmodule

// File: tb/tb_supply_reset_seq.sv
module tb_supply_reset_seq;
  localparam int HT  = 6;
  localparam int DT  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, live = 1'b0, mok = 1'b0, r2 = 1'b0, bok = 1'b0, mr_n = 1'b1;
  logic sys_rst_n, bus_block, r2_fail_n;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  supply_reset_seq #(.HOLD_TICKS(HT), .DEB_TICKS(DT), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .main_live_i(live),
    .main_ok_i(mok), .rail2_ok_i(r2), .batt_ok_i(bok), .mr_n_i(mr_n),
    .sys_rst_n_o(sys_rst_n), .bus_block_o(bus_block), .rail2_fail_n_o(r2_fail_n)
  );

  // Reference model built from the requirements
  logic m_s1, m_s2, m_lvl;
  int   m_run, m_cnt;

  function automatic logic f_cause(logic lv, logic ok, logic lvl);
    return !lv || !ok || !lvl;
  endfunction
  function automatic int f_next_cnt(logic c, logic tk, int cnt);
    if (c) return HT;
    if (tk && cnt != 0) return cnt - 1;
    return cnt;
  endfunction
  function automatic logic f_rst_n(logic c, int cnt);
    return !(c || cnt != 0);
  endfunction
  function automatic logic f_r2(logic ok, logic b, logic r);
    return (ok || b) ? r : 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_lvl <= 1'b1; m_run <= 0; m_cnt <= HT;
    end else begin
      m_s1  <= mr_n;
      m_s2  <= m_s1;
      m_cnt <= f_next_cnt(f_cause(live, mok, m_lvl), tick, m_cnt);
      if (tick) begin
        if (m_s2 == m_lvl) m_run <= 0;
        else if (m_run == DT - 1) begin m_lvl <= m_s2; m_run <= 0; end
        else m_run <= m_run + 1;
      end
    end
  end

  task automatic check(string req, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_all();
    logic e;
    e = f_rst_n(f_cause(live, mok, m_lvl), m_cnt);
    check("R3", sys_rst_n, e);
    check("R4", bus_block, !sys_rst_n);
    check("R7", r2_fail_n, f_r2(mok, bok, r2));
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    step(3);
    check("R1", sys_rst_n, 1'b0);
    check("R1", bus_block, 1'b1);
    live = 1; mok = 1; bok = 1; r2 = 1; tick = 1;
    rst_n = 1;
    step(1);
    check("R1", sys_rst_n, 1'b0);
    step(HT);
    check("R1", sys_rst_n, 1'b1);

    // R2: immediate assertion on supply drop, exact release count R3
    mok = 0; #1;
    check("R2", sys_rst_n, 1'b0);
    check("R4", bus_block, 1'b1);
    step(1); mok = 1;
    step(HT - 1);
    check("R3", sys_rst_n, 1'b0);
    step(1);
    check("R3", sys_rst_n, 1'b1);
    live = 0; #1;
    check("R2", sys_rst_n, 1'b0);
    step(1); live = 1;
    step(HT);
    check("R3", sys_rst_n, 1'b1);

    // R9: no ticks freezes the countdown
    mok = 0; step(1); mok = 1; tick = 0;
    step(3 * HT);
    check("R9", sys_rst_n, 1'b0);
    tick = 1; step(HT);
    check("R9", sys_rst_n, 1'b1);

    // R5: glitch one sample short of acceptance
    mr_n = 0; step(DT - 1); mr_n = 1;
    for (int i = 0; i < 6; i++) begin step(1); check("R5", sys_rst_n, 1'b1); end

    // R6: clean press, reset held HT ticks after debounced release
    mr_n = 0; step(2 + DT);
    check("R6", sys_rst_n, 1'b0);
    mr_n = 1; step(2 + DT);
    check("R6", sys_rst_n, 1'b0);
    step(HT - 1);
    check_all();
    step(1);
    check("R6", sys_rst_n, 1'b1);

    // R7 / R8
    r2 = 0; #1; check("R7", r2_fail_n, 1'b0);
    r2 = 1; #1; check("R7", r2_fail_n, 1'b1);
    mok = 0; bok = 1; r2 = 0; #1; check("R7", r2_fail_n, 1'b0);
    bok = 0; #1; check("R8", r2_fail_n, 1'b1);
    r2 = 1; #1; check("R8", r2_fail_n, 1'b1);
    r2 = 0; #1; check("R8", r2_fail_n, 1'b1);
    mok = 1; bok = 1; r2 = 1;
    step(HT + 2);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom % 3) == 0;
      mok  = ($urandom % 40) != 0;
      live = ($urandom % 200) != 0;
      bok  = ($urandom % 4) != 0;
      r2   = ($urandom % 5) != 0;
      if (($urandom % 60) == 0) mr_n = ~mr_n;
      else if (($urandom % 8) == 0 && !mr_n) mr_n = 1;
      #1;
      check_all();
      step(1);
    end
    finish_run();
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got=timeout exp=done");
      finish_run();
    end
  end
endmodule